// File: doc/BRIEF.md
# Multichannel Block Transfer Engine

This block moves blocks of 16-bit words from one memory space to another without the processor taking part. It has six channels. Each channel keeps its own source pointer, destination pointer, remaining element count, step indices, mode word and control word. Software programs these through a small register port. The engine then serves one ready channel at a time. For each element it reads from the source and writes the same data to the destination over a request/grant memory port. After each element it moves the two pointers according to the step rule chosen for each side.

A channel can wait for a selected sync event before each element. It can raise a pulse at half block and at block end. With reload set, it starts over from the values software last wrote. Two channels are set aside for external space, one for external reads and one for external writes. Configurations that pair spaces in a forbidden way are refused when the channel is enabled. The memories, the event sources and the external bus are outside the block.

Top module: `dma_xfer_ctrl`

## Requirements
- R1: After reset, every register reads as zero, no channel is enabled, `mem_req_o` is low and no interrupt pulses.
- R2: A register is addressed as `reg_addr_i = {channel[2:0], select[2:0]}`. The selects are: 0 source pointer, 1 destination pointer, 2 element count, 3 mode, 4 control, 5 source index, 6 destination index. The control word holds enable (bit 0), priority (bits 2:1), double-word (bit 3), event select (bits 7:4) and a read-only error flag (bit 8); its other bits read as zero. Each written value reads back unchanged, except that the enable and error bits follow R10.
- R3: An element reads at the source with `mem_we_o`=0 and then writes the read data to the destination with `mem_we_o`=1. The request, address and direction stay stable until `mem_gnt_i`, and read data is taken in the grant cycle. `mem_io_o` is high when the side being accessed has space code 01 (mode bits 7:6 for the source, bits 1:0 for the destination).
- R4: After each element, the source pointer steps by mode bits 10:8 and the destination pointer by mode bits 4:2. Code 0 holds, 1 increments, 2 decrements, and 3 to 7 add the side's 16-bit two's-complement index register.
- R5: With control bit 3 set, an element is two reads (pointer, pointer+1) followed by two writes (pointer, pointer+1). Increment and decrement then step by 2.
- R6: Among ready channels, the one with the highest priority field is served. Ties go round-robin, starting from the channel after the last one served (channel 0 first after reset). The choice is made only between elements.
- R7: A nonzero event select n makes each element wait for a pulse on `ev_i[n-1]`. A pulse is remembered until the channel is served, and no request is made before it.
- R8: When the last element of a block completes, `irq_end_o[ch]` pulses for one cycle if mode bit 14 is set. `irq_half_o[ch]` pulses when the remaining count falls to floor(start/2), for a start count of at least 2, if mode bit 13 is set.
- R9: At block end, if mode bit 15 is set, the pointers and count reload from the values last written and the channel stays enabled. Otherwise the enable bit clears.
- R10: Mode bit 11 marks the source as external and mode bit 5 marks the destination as external, shown on `mem_ext_o`. An enable request is refused if any of these holds: an external source on a channel other than 0, an external destination on a channel other than 1, both sides external, one side external with space code 01 on the other side, external with double-word, external with an event select, or a zero count. A refused request sets the error bit, keeps the channel disabled and produces no memory request. A legal enable write clears the error bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 6 | Channel and register select |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Register read data (combinational) |
| ev_i | input | NUM_EV | Sync event pulses |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_addr_o | output | 16 | Access address |
| mem_wdata_o | output | 16 | Write data |
| mem_ext_o | output | 1 | Access targets external space |
| mem_io_o | output | 1 | Access targets peripheral space |
| mem_gnt_i | input | 1 | Access accepted this cycle |
| mem_rdata_i | input | 16 | Read data, valid with grant |
| irq_half_o | output | NUM_CH | Half-block pulse per channel |
| irq_end_o | output | NUM_CH | Block-end pulse per channel |

## Verification
On every cycle the assertions check the following:
- A request that has not been granted keeps its address and direction.
- The step strobe lasts a single cycle.
- The arbiter never picks a channel that is not ready, and never picks one with lower priority than another ready channel.
- External reads come only from the reserved read channel, and external accesses are never double-word.
- An error flag never coexists with an enable.
- An end pulse appears only when enabled.

Other behaviours can be shown only by the bench's scenarios, which compare every memory access against a scoreboard. These are the exact pointer sequences under each step mode, the double-word ordering, round-robin order among equal priorities, waiting for sync events, the reload at block end, the half-block timing and the refusal of each forbidden configuration.

// File: rtl/dma_xfer_pkg.sv
package dma_xfer_pkg;

    typedef logic [15:0] word_t;

    localparam logic [1:0] SP_IO = 2'b01;

    typedef struct packed {
        logic       reload;
        logic       end_ie;
        logic       half_ie;
        logic       rsvd;
        logic       src_ext;
        logic [2:0] src_step;
        logic [1:0] src_space;
        logic       dst_ext;
        logic [2:0] dst_step;
        logic [1:0] dst_space;
    } mode_t;

    typedef struct packed {
        logic [6:0] rsvd;
        logic       err;
        logic [3:0] ev_sel;
        logic       dword;
        logic [1:0] prio;
        logic       en;
    } ctrl_t;

    typedef struct packed {
        word_t src;
        word_t dst;
        word_t cnt;
        word_t sidx;
        word_t didx;
        mode_t mode;
        ctrl_t ctrl;
        logic  ready;
    } chan_view_t;

    typedef enum logic [1:0] {
        ES_IDLE,
        ES_RD,
        ES_WR,
        ES_UPD
    } eng_state_e;

    function automatic word_t next_addr(word_t a, logic [2:0] code, word_t idx, logic dword);
        word_t unit;
        unit = dword ? 16'd2 : 16'd1;
        case (code)
            3'd0:    return a;
            3'd1:    return a + unit;
            3'd2:    return a - unit;
            default: return a + idx;
        endcase
    endfunction

    function automatic logic cfg_bad(mode_t m, ctrl_t c, word_t cnt, logic rd_ok, logic wr_ok);
        logic any_ext;
        any_ext = m.src_ext | m.dst_ext;
        return (cnt == 16'd0)
             | (m.src_ext & m.dst_ext)
             | (m.src_ext & !rd_ok)
             | (m.dst_ext & !wr_ok)
             | (m.src_ext & (m.dst_space == SP_IO))
             | (m.dst_ext & (m.src_space == SP_IO))
             | (any_ext & c.dword)
             | (any_ext & (c.ev_sel != 4'd0));
    endfunction

endpackage

// File: rtl/dma_chan_ctx.sv
module dma_chan_ctx
    import dma_xfer_pkg::*;
#(
    parameter int NUM_EV = 4,
    parameter bit RD_EXT_OK = 1'b0,
    parameter bit WR_EXT_OK = 1'b0
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en_i,
    input  logic [2:0]  wr_sel_i,
    input  word_t       wr_data_i,
    input  logic [NUM_EV-1:0] ev_i,
    input  logic        grant_i,
    input  logic        step_i,
    output chan_view_t  view_o,
    output logic        irq_half_o,
    output logic        irq_end_o
);
    word_t src_q, dst_q, cnt_q, sidx_q, didx_q;
    word_t sh_src, sh_dst, sh_cnt;
    mode_t mode_q;
    ctrl_t ctrl_q, ctrl_w;
    logic  pend_q, ev_hit;
    word_t cnt_after;

    assign ctrl_w    = ctrl_t'(wr_data_i);
    assign cnt_after = cnt_q - 16'd1;

    always_comb begin
        ev_hit = 1'b0;
        for (int e = 0; e < NUM_EV; e++) begin
            if (int'(ctrl_q.ev_sel) == e + 1) ev_hit = ev_i[e];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            src_q <= '0; dst_q <= '0; cnt_q <= '0; sidx_q <= '0; didx_q <= '0;
            sh_src <= '0; sh_dst <= '0; sh_cnt <= '0;
            mode_q <= '0; ctrl_q <= '0; pend_q <= 1'b0;
            irq_half_o <= 1'b0; irq_end_o <= 1'b0;
        end else begin
            irq_half_o <= 1'b0;
            irq_end_o  <= 1'b0;
            pend_q <= (pend_q & ~grant_i) | ev_hit;
            if (step_i) begin
                src_q <= next_addr(src_q, mode_q.src_step, sidx_q, ctrl_q.dword);
                dst_q <= next_addr(dst_q, mode_q.dst_step, didx_q, ctrl_q.dword);
                cnt_q <= cnt_after;
                if (mode_q.half_ie && sh_cnt >= 16'd2 && cnt_after == (sh_cnt >> 1))
                    irq_half_o <= 1'b1;
                if (cnt_q == 16'd1) begin
                    irq_end_o <= mode_q.end_ie;
                    if (mode_q.reload) begin
                        src_q <= sh_src;
                        dst_q <= sh_dst;
                        cnt_q <= sh_cnt;
                    end else begin
                        ctrl_q.en <= 1'b0;
                    end
                end
            end
            if (wr_en_i) begin
                case (wr_sel_i)
                    3'd0: begin src_q <= wr_data_i; sh_src <= wr_data_i; end
                    3'd1: begin dst_q <= wr_data_i; sh_dst <= wr_data_i; end
                    3'd2: begin cnt_q <= wr_data_i; sh_cnt <= wr_data_i; end
                    3'd3: mode_q <= mode_t'(wr_data_i);
                    3'd4: begin
                        ctrl_q.prio   <= ctrl_w.prio;
                        ctrl_q.dword  <= ctrl_w.dword;
                        ctrl_q.ev_sel <= ctrl_w.ev_sel;
                        if (ctrl_w.en && cfg_bad(mode_q, ctrl_w, cnt_q, RD_EXT_OK, WR_EXT_OK)) begin
                            ctrl_q.en  <= 1'b0;
                            ctrl_q.err <= 1'b1;
                        end else begin
                            ctrl_q.en  <= ctrl_w.en;
                            ctrl_q.err <= 1'b0;
                        end
                    end
                    3'd5: sidx_q <= wr_data_i;
                    3'd6: didx_q <= wr_data_i;
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        view_o.src   = src_q;
        view_o.dst   = dst_q;
        view_o.cnt   = cnt_q;
        view_o.sidx  = sidx_q;
        view_o.didx  = didx_q;
        view_o.mode  = mode_q;
        view_o.ctrl  = ctrl_q;
        view_o.ready = ctrl_q.en && (ctrl_q.ev_sel == 4'd0 || pend_q);
    end

    // R10: a refused configuration never leaves the channel enabled
    a_r10_err_excludes_en: assert property (@(posedge clk) disable iff (rst)
        ctrl_q.err |-> !ctrl_q.en);

    // R8: an end pulse only follows a step taken while enabled
    a_r8_end_after_step: assert property (@(posedge clk) disable iff (rst)
        irq_end_o |-> $past(step_i) && $past(ctrl_q.en));

endmodule

// File: rtl/dma_arbiter.sv
module dma_arbiter #(
    parameter int NUM_CH = 6,
    parameter int CHW = 3
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [NUM_CH-1:0]       ready_i,
    input  logic [NUM_CH-1:0][1:0]  prio_i,
    input  logic                    take_i,
    output logic                    valid_o,
    output logic [CHW-1:0]          ch_o
);
    logic [CHW-1:0] last_q;
    logic [1:0]     best_p;
    int             best_r;

    always_comb begin
        valid_o = 1'b0;
        ch_o    = '0;
        best_p  = '0;
        best_r  = NUM_CH;
        for (int i = 0; i < NUM_CH; i++) begin
            automatic int rank = (i + NUM_CH - int'(last_q) - 1) % NUM_CH;
            if (ready_i[i] && (!valid_o || prio_i[i] > best_p ||
                               (prio_i[i] == best_p && rank < best_r))) begin
                valid_o = 1'b1;
                ch_o    = CHW'(i);
                best_p  = prio_i[i];
                best_r  = rank;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)         last_q <= CHW'(NUM_CH - 1);
        else if (take_i) last_q <= ch_o;
    end

    // R6: the winner is ready
    a_r6_winner_ready: assert property (@(posedge clk) disable iff (rst)
        valid_o |-> ready_i[ch_o]);

    // R6: no ready channel outranks the winner
    always_ff @(posedge clk) begin
        if (!rst && valid_o) begin
            for (int i = 0; i < NUM_CH; i++) begin
                a_r6_no_higher: assert (!ready_i[i] || prio_i[i] <= prio_i[ch_o]);
            end
        end
    end

endmodule

// File: rtl/dma_engine.sv
module dma_engine
    import dma_xfer_pkg::*;
#(
    parameter int CHW = 3
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           arb_valid_i,
    input  logic [CHW-1:0] arb_ch_i,
    input  word_t          src_i,
    input  word_t          dst_i,
    input  logic           dword_i,
    input  logic           src_ext_i,
    input  logic           dst_ext_i,
    input  logic           src_io_i,
    input  logic           dst_io_i,
    output logic           take_o,
    output logic           step_o,
    output logic [CHW-1:0] cur_o,
    output logic           mem_req_o,
    output logic           mem_we_o,
    output word_t          mem_addr_o,
    output word_t          mem_wdata_o,
    output logic           mem_ext_o,
    output logic           mem_io_o,
    input  logic           mem_gnt_i,
    input  word_t          mem_rdata_i
);
    eng_state_e st_q;
    logic       wsel_q;
    word_t      buf_q [2];
    logic       last_word;

    assign take_o    = (st_q == ES_IDLE) && arb_valid_i;
    assign step_o    = (st_q == ES_UPD);
    assign last_word = !dword_i || wsel_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= ES_IDLE; cur_o <= '0; wsel_q <= 1'b0;
            buf_q[0] <= '0; buf_q[1] <= '0;
        end else begin
            case (st_q)
                ES_IDLE: if (take_o) begin
                    cur_o  <= arb_ch_i;
                    wsel_q <= 1'b0;
                    st_q   <= ES_RD;
                end
                ES_RD: if (mem_gnt_i) begin
                    buf_q[wsel_q] <= mem_rdata_i;
                    wsel_q <= !last_word;
                    if (last_word) st_q <= ES_WR;
                end
                ES_WR: if (mem_gnt_i) begin
                    wsel_q <= !last_word;
                    if (last_word) st_q <= ES_UPD;
                end
                default: st_q <= ES_IDLE;
            endcase
        end
    end

    always_comb begin
        mem_req_o   = (st_q == ES_RD) || (st_q == ES_WR);
        mem_we_o    = (st_q == ES_WR);
        mem_addr_o  = (mem_we_o ? dst_i : src_i) + {15'd0, wsel_q};
        mem_wdata_o = buf_q[wsel_q];
        mem_ext_o   = mem_req_o && (mem_we_o ? dst_ext_i : src_ext_i);
        mem_io_o    = mem_req_o && (mem_we_o ? dst_io_i : src_io_i);
    end

    // R3: an ungranted request holds address and direction
    a_r3_req_held: assert property (@(posedge clk) disable iff (rst)
        mem_req_o && !mem_gnt_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o));

    // R4: pointers advance once per element
    a_r4_step_single: assert property (@(posedge clk) disable iff (rst)
        step_o |=> !step_o);

endmodule

// File: rtl/dma_xfer_ctrl.sv
module dma_xfer_ctrl
    import dma_xfer_pkg::*;
#(
    parameter int NUM_CH    = 6,
    parameter int NUM_EV    = 4,
    parameter int EXT_RD_CH = 0,
    parameter int EXT_WR_CH = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we_i,
    input  logic [5:0]        reg_addr_i,
    input  logic [15:0]       reg_wdata_i,
    output logic [15:0]       reg_rdata_o,
    input  logic [NUM_EV-1:0] ev_i,
    output logic              mem_req_o,
    output logic              mem_we_o,
    output logic [15:0]       mem_addr_o,
    output logic [15:0]       mem_wdata_o,
    output logic              mem_ext_o,
    output logic              mem_io_o,
    input  logic              mem_gnt_i,
    input  logic [15:0]       mem_rdata_i,
    output logic [NUM_CH-1:0] irq_half_o,
    output logic [NUM_CH-1:0] irq_end_o
);
    localparam int CHW = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

    chan_view_t              views [NUM_CH];
    logic [NUM_CH-1:0]       ready;
    logic [NUM_CH-1:0][1:0]  prio;
    logic                    arb_valid, take, step;
    logic [CHW-1:0]          arb_ch, cur;
    logic [2:0]              reg_ch, reg_sel;
    chan_view_t              cv;

    assign reg_ch  = reg_addr_i[5:3];
    assign reg_sel = reg_addr_i[2:0];

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        dma_chan_ctx #(
            .NUM_EV    (NUM_EV),
            .RD_EXT_OK (g == EXT_RD_CH),
            .WR_EXT_OK (g == EXT_WR_CH)
        ) u_ctx (
            .clk        (clk),
            .rst        (rst),
            .wr_en_i    (reg_we_i && int'(reg_ch) == g),
            .wr_sel_i   (reg_sel),
            .wr_data_i  (reg_wdata_i),
            .ev_i       (ev_i),
            .grant_i    (take && int'(arb_ch) == g),
            .step_i     (step && int'(cur) == g),
            .view_o     (views[g]),
            .irq_half_o (irq_half_o[g]),
            .irq_end_o  (irq_end_o[g])
        );
        assign ready[g] = views[g].ready;
        assign prio[g]  = views[g].ctrl.prio;
    end

    dma_arbiter #(.NUM_CH(NUM_CH), .CHW(CHW)) u_arb (
        .clk     (clk),
        .rst     (rst),
        .ready_i (ready),
        .prio_i  (prio),
        .take_i  (take),
        .valid_o (arb_valid),
        .ch_o    (arb_ch)
    );

    assign cv = views[cur];

    dma_engine #(.CHW(CHW)) u_eng (
        .clk         (clk),
        .rst         (rst),
        .arb_valid_i (arb_valid),
        .arb_ch_i    (arb_ch),
        .src_i       (cv.src),
        .dst_i       (cv.dst),
        .dword_i     (cv.ctrl.dword),
        .src_ext_i   (cv.mode.src_ext),
        .dst_ext_i   (cv.mode.dst_ext),
        .src_io_i    (cv.mode.src_space == SP_IO),
        .dst_io_i    (cv.mode.dst_space == SP_IO),
        .take_o      (take),
        .step_o      (step),
        .cur_o       (cur),
        .mem_req_o   (mem_req_o),
        .mem_we_o    (mem_we_o),
        .mem_addr_o  (mem_addr_o),
        .mem_wdata_o (mem_wdata_o),
        .mem_ext_o   (mem_ext_o),
        .mem_io_o    (mem_io_o),
        .mem_gnt_i   (mem_gnt_i),
        .mem_rdata_i (mem_rdata_i)
    );

    always_comb begin
        reg_rdata_o = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (int'(reg_ch) == i) begin
                case (reg_sel)
                    3'd0: reg_rdata_o = views[i].src;
                    3'd1: reg_rdata_o = views[i].dst;
                    3'd2: reg_rdata_o = views[i].cnt;
                    3'd3: reg_rdata_o = views[i].mode;
                    3'd4: reg_rdata_o = views[i].ctrl;
                    3'd5: reg_rdata_o = views[i].sidx;
                    3'd6: reg_rdata_o = views[i].didx;
                    default: reg_rdata_o = '0;
                endcase
            end
        end
    end

    // R10: external reads only on the reserved read channel
    a_r10_ext_rd_chan: assert property (@(posedge clk) disable iff (rst)
        mem_req_o && mem_ext_o && !mem_we_o |-> int'(cur) == EXT_RD_CH);

    // R10: external writes only on the reserved write channel
    a_r10_ext_wr_chan: assert property (@(posedge clk) disable iff (rst)
        mem_req_o && mem_ext_o && mem_we_o |-> int'(cur) == EXT_WR_CH);

    // R10: external accesses are single-word
    a_r10_ext_single: assert property (@(posedge clk) disable iff (rst)
        mem_req_o && mem_ext_o |-> !cv.ctrl.dword);

endmodule

// File: tb/dma_xfer_ctrl_bench.sv
module dma_xfer_ctrl_bench;
    localparam int NCH = 6;
    localparam int NEV = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic reg_we = 1'b0;
    logic [5:0] reg_addr = '0;
    logic [15:0] reg_wdata = '0, reg_rdata;
    logic [NEV-1:0] ev = '0;
    logic mem_req, mem_we, mem_ext, mem_io;
    logic mem_gnt = 1'b0;
    logic [15:0] mem_addr, mem_wdata, mem_rdata;
    logic [NCH-1:0] irq_half, irq_end;

    always #5 clk = ~clk;

    dma_xfer_ctrl u_dma_xfer_ctrl (
        .clk(clk), .rst(rst), .reg_we_i(reg_we), .reg_addr_i(reg_addr),
        .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .ev_i(ev),
        .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
        .mem_wdata_o(mem_wdata), .mem_ext_o(mem_ext), .mem_io_o(mem_io),
        .mem_gnt_i(mem_gnt), .mem_rdata_i(mem_rdata),
        .irq_half_o(irq_half), .irq_end_o(irq_end)
    );

    typedef struct {
        logic        we;
        logic [15:0] addr;
        logic [15:0] data;
        logic        ext;
        logic        io;
        string       tag;
    } txn_t;

    txn_t q[$];
    int checks = 0, errors = 0, cyc = 0;
    int half_cnt [NCH];
    int end_cnt [NCH];
    logic tog = 1'b0;

    function automatic logic [15:0] rd_val(logic [15:0] a, logic x, logic io);
        return a ^ 16'h5A00 ^ (x ? 16'h8000 : 16'h0) ^ (io ? 16'h4000 : 16'h0);
    endfunction
    assign mem_rdata = rd_val(mem_addr, mem_ext, mem_io);

    task automatic chk(input logic ok, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", what, act, exp);
        end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // grant model, scoreboard monitor, irq counters, watchdog
    always @(negedge clk) begin
        cyc++;
        if (mem_req) begin mem_gnt = tog; tog = !tog; end
        else mem_gnt = 1'b0;
        if (mem_req && mem_gnt) begin
            if (q.size() == 0) begin
                chk(1'b0, "unexpected access", int'(mem_addr), 0);
            end else begin
                automatic txn_t e = q.pop_front();
                chk(mem_we == e.we && mem_addr == e.addr && mem_ext == e.ext && mem_io == e.io &&
                    (!e.we || mem_wdata == e.data),
                    e.tag, int'({mem_we, mem_ext, mem_io, mem_addr}), int'({e.we, e.ext, e.io, e.addr}));
            end
        end
        for (int i = 0; i < NCH; i++) begin
            if (irq_half[i]) half_cnt[i]++;
            if (irq_end[i]) end_cnt[i]++;
        end
        if (cyc > 150000) begin
            chk(1'b0, "watchdog", cyc, 0);
            summary();
        end
    end

    task automatic push_elem(input logic [15:0] s, input logic [15:0] d, input logic sx, input logic sio,
                             input logic dx, input logic dio, input logic dw, input string tag);
        int n = dw ? 2 : 1;
        for (int k = 0; k < n; k++)
            q.push_back('{1'b0, s + 16'(k), 16'h0, sx, sio, tag});
        for (int k = 0; k < n; k++)
            q.push_back('{1'b1, d + 16'(k), rd_val(s + 16'(k), sx, sio), dx, dio, tag});
    endtask

    task automatic wr(input int ch, input int sel, input logic [15:0] v);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = 6'((ch << 3) | sel); reg_wdata = v;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input int ch, input int sel, output logic [15:0] v);
        @(negedge clk);
        reg_addr = 6'((ch << 3) | sel);
        #1 v = reg_rdata;
    endtask

    task automatic setup(input int ch, input logic [15:0] s, input logic [15:0] d,
                         input logic [15:0] n, input logic [15:0] m);
        wr(ch, 0, s); wr(ch, 1, d); wr(ch, 2, n); wr(ch, 3, m);
    endtask

    task automatic pulse(input int e);
        @(negedge clk); ev[e] = 1'b1;
        @(negedge clk); ev[e] = 1'b0;
    endtask

    task automatic drain();
        while (q.size() != 0) @(negedge clk);
        repeat (6) @(negedge clk);
    endtask

    logic [15:0] v;

    initial begin
        for (int i = 0; i < NCH; i++) begin half_cnt[i] = 0; end_cnt[i] = 0; end
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        rd(0, 0, v); chk(v == 0, "R1 src reset", v, 0);
        rd(3, 4, v); chk(v == 0, "R1 ctrl reset", v, 0);
        chk(mem_req == 0 && irq_end == 0 && irq_half == 0, "R1 outputs idle", int'(mem_req), 0);

        // R2: register readback
        wr(2, 5, 16'hBEEF); rd(2, 5, v); chk(v == 16'hBEEF, "R2 sidx readback", v, 16'hBEEF);
        wr(5, 3, 16'h1234); rd(5, 3, v); chk(v == 16'h1234, "R2 mode readback", v, 16'h1234);
        wr(5, 4, 16'hFFF6); rd(5, 4, v); chk(v == 16'h00F6, "R2 ctrl fields", v, 16'h00F6);
        wr(5, 4, 16'h0000);

        // R3 R4 R8 R9: ch0 inc/inc, 4 elements, half and end irq
        setup(0, 16'h0100, 16'h0200, 4, 16'h6104);
        for (int k = 0; k < 4; k++) push_elem(16'h0100 + 16'(k), 16'h0200 + 16'(k), 0, 0, 0, 0, 0, "R3 inc copy");
        wr(0, 4, 16'h0001);
        drain();
        rd(0, 4, v); chk(v[0] == 0, "R9 enable cleared", v, 0);
        rd(0, 0, v); chk(v == 16'h0104, "R4 src incremented", v, 16'h0104);
        rd(0, 1, v); chk(v == 16'h0204, "R4 dst incremented", v, 16'h0204);
        chk(end_cnt[0] == 1, "R8 end pulse", end_cnt[0], 1);
        chk(half_cnt[0] == 1, "R8 half pulse", half_cnt[0], 1);

        // R4: hold source, indexed destination
        wr(1, 6, 16'd5);
        setup(1, 16'h0300, 16'h0400, 3, 16'h000C);
        push_elem(16'h0300, 16'h0400, 0, 0, 0, 0, 0, "R4 hold/index");
        push_elem(16'h0300, 16'h0405, 0, 0, 0, 0, 0, "R4 hold/index");
        push_elem(16'h0300, 16'h040A, 0, 0, 0, 0, 0, "R4 hold/index");
        wr(1, 4, 16'h0001);
        drain();
        rd(1, 1, v); chk(v == 16'h040F, "R4 dst index sum", v, 16'h040F);
        chk(end_cnt[1] == 0, "R8 no end pulse when disabled", end_cnt[1], 0);

        // R4: negative source index
        wr(4, 5, 16'hFFFE);
        setup(4, 16'h0900, 16'h0A00, 2, 16'h0300);
        push_elem(16'h0900, 16'h0A00, 0, 0, 0, 0, 0, "R4 neg index");
        push_elem(16'h08FE, 16'h0A00, 0, 0, 0, 0, 0, "R4 neg index");
        wr(4, 4, 16'h0001);
        drain();

        // R5: double word, decrement both sides
        setup(2, 16'h0050, 16'h0600, 2, 16'h0208);
        push_elem(16'h0050, 16'h0600, 0, 0, 0, 0, 1, "R5 dword");
        push_elem(16'h004E, 16'h05FE, 0, 0, 0, 0, 1, "R5 dword");
        wr(2, 4, 16'h0009);
        drain();
        rd(2, 0, v); chk(v == 16'h004C, "R5 dword step 2", v, 16'h004C);

        // R6 R7: priority under a shared event
        setup(3, 16'h1000, 16'h1100, 2, 16'h0104);
        setup(4, 16'h2000, 16'h2100, 2, 16'h0104);
        wr(3, 4, 16'h0013);
        wr(4, 4, 16'h0017);
        repeat (8) @(negedge clk);
        chk(mem_req == 0, "R7 waits for event", int'(mem_req), 0);
        for (int k = 0; k < 2; k++) begin
            push_elem(16'h2000 + 16'(k), 16'h2100 + 16'(k), 0, 0, 0, 0, 0, "R6 high prio first");
            push_elem(16'h1000 + 16'(k), 16'h1100 + 16'(k), 0, 0, 0, 0, 0, "R6 low prio second");
            pulse(0);
            drain();
        end

        // R6: round-robin among equal priorities (last served was ch3)
        setup(3, 16'h3000, 16'h3100, 2, 16'h0104);
        setup(5, 16'h5000, 16'h5100, 2, 16'h0104);
        wr(3, 4, 16'h0025);
        wr(5, 4, 16'h0025);
        for (int k = 0; k < 2; k++) begin
            push_elem(16'h5000 + 16'(k), 16'h5100 + 16'(k), 0, 0, 0, 0, 0, "R6 rr ch5");
            push_elem(16'h3000 + 16'(k), 16'h3100 + 16'(k), 0, 0, 0, 0, 0, "R6 rr ch3");
            pulse(1);
            drain();
        end

        // R9: reload at block end
        setup(0, 16'h0700, 16'h0800, 2, 16'hC104);
        wr(0, 4, 16'h0031);
        push_elem(16'h0700, 16'h0800, 0, 0, 0, 0, 0, "R9 reload"); pulse(2); drain();
        push_elem(16'h0701, 16'h0801, 0, 0, 0, 0, 0, "R9 reload"); pulse(2); drain();
        push_elem(16'h0700, 16'h0800, 0, 0, 0, 0, 0, "R9 reload"); pulse(2); drain();
        rd(0, 4, v); chk(v[0] == 1, "R9 stays enabled", v, 1);
        rd(0, 0, v); chk(v == 16'h0701, "R9 src after reload", v, 16'h0701);
        rd(0, 2, v); chk(v == 16'd1, "R9 count after reload", v, 1);
        chk(end_cnt[0] == 2, "R8 end pulse on reload", end_cnt[0], 2);
        wr(0, 4, 16'h0000);

        // R10: legal external read on ch0 and external write on ch1
        setup(0, 16'h0010, 16'h0020, 2, 16'h0904);
        push_elem(16'h0010, 16'h0020, 1, 0, 0, 0, 0, "R10 ext read");
        push_elem(16'h0011, 16'h0021, 1, 0, 0, 0, 0, "R10 ext read");
        wr(0, 4, 16'h0001);
        drain();
        setup(1, 16'h0030, 16'h0040, 1, 16'h0124);
        push_elem(16'h0030, 16'h0040, 0, 0, 1, 0, 0, "R10 ext write");
        wr(1, 4, 16'h0001);
        drain();

        // R10: refused configurations
        setup(2, 16'h0010, 16'h0020, 1, 16'h0904);
        wr(2, 4, 16'h0001); rd(2, 4, v); chk(v == 16'h0100, "R10 ext src wrong channel", v, 16'h0100);
        setup(0, 16'h0010, 16'h0020, 1, 16'h0820);
        wr(0, 4, 16'h0001); rd(0, 4, v); chk(v == 16'h0100, "R10 both external", v, 16'h0100);
        wr(0, 3, 16'h0801);
        wr(0, 4, 16'h0001); rd(0, 4, v); chk(v == 16'h0100, "R10 ext with peripheral", v, 16'h0100);
        setup(1, 16'h0030, 16'h0040, 1, 16'h0020);
        wr(1, 4, 16'h0009); rd(1, 4, v); chk(v == 16'h0108, "R10 ext with dword", v, 16'h0108);
        setup(3, 16'h0060, 16'h0070, 0, 16'h0144);
        wr(3, 4, 16'h0001); rd(3, 4, v); chk(v == 16'h0100, "R10 zero count", v, 16'h0100);
        repeat (10) @(negedge clk);
        chk(mem_req == 0 && q.size() == 0, "R10 refused makes no access", int'(mem_req), 0);

        // R3 R10: peripheral source, error cleared by legal enable
        wr(3, 2, 16'd1);
        push_elem(16'h0060, 16'h0070, 0, 1, 0, 0, 0, "R3 peripheral source");
        wr(3, 4, 16'h0001);
        drain();
        rd(3, 4, v); chk(v == 16'h0000, "R10 error cleared", v, 0);

        chk(q.size() == 0, "R3 scoreboard empty", q.size(), 0);
        summary();
    end

endmodule